// File: doc/BRIEF.md
# Usefulness-Gated L2 Install Tracker

This block sits beside an L1 instruction cache and decides which lines leaving that cache are written into the shared L2. A line brought in by a prefetch bypasses the L2 when it is filled. It earns an L2 install only if the core actually fetches from it while it sits in the L1. The block holds two flags for every L1 frame: whether the current occupant arrived by prefetch, and whether a demand access has touched it since then.

The cache controller reports three kinds of event: fills (frame index and whether the fill was a prefetch), demand hits (frame index), and evictions (frame index and line address). A prefetched line that is evicted after being used produces an install request carrying its line address. The request goes through a small FIFO to the L2 with a valid/ready handshake. A prefetched line that was never used is dropped silently. Lines filled on demand follow the normal path and never produce a request here. When the FIFO is full, the block holds back its eviction acknowledge until space frees up.

Top module: `pfl2_gate`

## Requirements
- R1: After synchronous reset every frame's flags are clear, `inst_vld` is 0 and `evict_ack` is 1.
- R2: A fill with `fill_pf`=1 produces no install request. `inst_vld` stays 0 when no eviction is accepted.
- R3: A demand hit on a frame whose occupant was prefetch-filled marks it used. A later accepted eviction of that frame pushes exactly one request whose `inst_addr` equals `evict_addr`.
- R4: An accepted eviction of a prefetch-filled frame with no demand hit since its fill produces no request.
- R5: A frame filled with `fill_pf`=0 never produces a request on eviction, even after demand hits.
- R6: A fill into a frame replaces both flags of the previous occupant. The used flag restarts at 0 and the prefetched flag takes the new `fill_pf`.
- R7: When a demand hit and an eviction name the same frame in the same cycle, the hit counts as a use for that eviction's decision.
- R8: Requests leave in the order their evictions were accepted. While `inst_vld`=1 and `inst_rdy`=0, `inst_addr` holds steady.
- R9: While the FIFO holds `DEPTH` requests, `evict_ack` is 0 and the presented eviction is not consumed. It is accepted once a request drains.
- R10: An accepted eviction clears the frame's flags, so a second eviction of that frame with no fill in between produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_vld | input | 1 | A line is written into a frame this cycle |
| fill_frame | input | FIDX_W | Frame receiving the fill |
| fill_pf | input | 1 | 1 = fill caused by a prefetch, 0 = demand fill |
| hit_vld | input | 1 | Demand access hits a frame this cycle |
| hit_frame | input | FIDX_W | Frame hit by the demand access |
| evict_vld | input | 1 | Eviction presented; held until acknowledged |
| evict_frame | input | FIDX_W | Frame being vacated |
| evict_addr | input | ADDR_W | Line address of the evicted line |
| evict_ack | output | 1 | Eviction accepted on this edge when high together with `evict_vld` |
| inst_vld | output | 1 | An L2 install request is pending |
| inst_addr | output | ADDR_W | Line address to install in the L2 |
| inst_rdy | input | 1 | L2 takes the pending request on this edge |

## Verification
The assertions assume the controller holds `evict_vld` and its frame and address steady until `evict_ack` is seen. They also assume that any frame named in a hit was filled earlier. In the stimulus, every event is driven at the falling edge. Evictions stay up until the acknowledge has been sampled high. Hits target only frames already filled in the same scenario. A separate model array predicts each eviction's outcome. That model is built only from the requirements, including the case where a hit and an eviction land in the same cycle and the case where the FIFO is full while an eviction waits.

// File: rtl/pfl2_pkg.sv
package pfl2_pkg;

    typedef struct packed {
        logic pf;    // occupant arrived by prefetch
        logic used;  // demand touched it since fill
    } frame_flags_t;

    localparam frame_flags_t FLAGS_CLEAR = '{pf: 1'b0, used: 1'b0};

    // A line earns an L2 install only if it came by prefetch and was used,
    // counting a demand hit landing in the same cycle as the eviction.
    function automatic logic earns_install(frame_flags_t f, logic hit_now);
        return f.pf && (f.used || hit_now);
    endfunction

endpackage

// File: rtl/pfl2_frame_tbl.sv
module pfl2_frame_tbl
    import pfl2_pkg::*;
#(
    parameter int FRAMES = 32,
    localparam int FIDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_vld,
    input  logic [FIDX_W-1:0] fill_frame,
    input  logic              fill_pf,
    input  logic              hit_vld,
    input  logic [FIDX_W-1:0] hit_frame,
    input  logic              clr_vld,
    input  logic [FIDX_W-1:0] clr_frame,
    input  logic [FIDX_W-1:0] rd_frame,
    output frame_flags_t      rd_flags
);

    logic [FRAMES-1:0] pf_q;
    logic [FRAMES-1:0] used_q;

    // Priority per frame: fill overwrites, then eviction clears, then hit marks.
    always_ff @(posedge clk) begin
        if (rst) begin
            pf_q   <= '0;
            used_q <= '0;
        end else begin
            for (int i = 0; i < FRAMES; i++) begin
                if (fill_vld && fill_frame == FIDX_W'(i)) begin
                    pf_q[i]   <= fill_pf;
                    used_q[i] <= 1'b0;
                end else if (clr_vld && clr_frame == FIDX_W'(i)) begin
                    pf_q[i]   <= 1'b0;
                    used_q[i] <= 1'b0;
                end else if (hit_vld && hit_frame == FIDX_W'(i) && pf_q[i]) begin
                    used_q[i] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_flags.pf   = pf_q[rd_frame];
        rd_flags.used = used_q[rd_frame];
    end

    // R3: hit on a prefetched occupant leaves it marked used
    a_r3_hit_marks_used: assert property (@(posedge clk) disable iff (rst)
        (hit_vld && pf_q[hit_frame]
         && !(fill_vld && fill_frame == hit_frame)
         && !(clr_vld && clr_frame == hit_frame))
        |=> used_q[$past(hit_frame)]);

    // R6: fill replaces the previous occupant's flags
    a_r6_fill_overwrites: assert property (@(posedge clk) disable iff (rst)
        fill_vld |=> (!used_q[$past(fill_frame)]
                      && pf_q[$past(fill_frame)] == $past(fill_pf)));

endmodule

// File: rtl/pfl2_evict_dec.sv
module pfl2_evict_dec
    import pfl2_pkg::*;
#(
    parameter int FRAMES = 32,
    parameter int ADDR_W = 34,
    localparam int FIDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evict_vld,
    input  logic [FIDX_W-1:0] evict_frame,
    input  logic [ADDR_W-1:0] evict_addr,
    input  frame_flags_t      evict_flags,
    input  logic              hit_vld,
    input  logic [FIDX_W-1:0] hit_frame,
    input  logic              q_full,
    output logic              evict_ack,
    output logic              push_vld,
    output logic [ADDR_W-1:0] push_addr,
    output logic              clr_vld,
    output logic [FIDX_W-1:0] clr_frame
);

    logic accept;
    logic hit_same;

    always_comb begin
        evict_ack = !q_full;
        accept    = evict_vld && evict_ack;
        hit_same  = hit_vld && (hit_frame == evict_frame);
        push_vld  = accept && earns_install(evict_flags, hit_same);
        push_addr = evict_addr;
        clr_vld   = accept;
        clr_frame = evict_frame;
    end

    // R4/R5: a frame not holding a prefetched line never pushes
    a_r4_unprefetched_no_push: assert property (@(posedge clk) disable iff (rst)
        (evict_vld && !evict_flags.pf) |-> !push_vld);

    // R9: stalled eviction is not consumed
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
        q_full |-> (!clr_vld && !push_vld));

endmodule

// File: rtl/pfl2_fifo.sv
module pfl2_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_vld,
    output logic [W-1:0] out_data,
    input  logic         out_rdy
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full     = (cnt_q == CNT_W'(DEPTH));
        out_vld  = (cnt_q != '0);
        out_data = mem_q[rd_q];
        pop      = out_vld && out_rdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q <= bump(wr_q);
            end
            if (pop) begin
                rd_q <= bump(rd_q);
            end
            if (push && !pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_q] <= push_data;
        end
    end

    // R9: no push arrives while the queue is full
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

endmodule

// File: rtl/pfl2_gate.sv
module pfl2_gate
    import pfl2_pkg::*;
#(
    parameter int FRAMES = 32,
    parameter int ADDR_W = 34,
    parameter int DEPTH  = 4,
    localparam int FIDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_vld,
    input  logic [FIDX_W-1:0] fill_frame,
    input  logic              fill_pf,
    input  logic              hit_vld,
    input  logic [FIDX_W-1:0] hit_frame,
    input  logic              evict_vld,
    input  logic [FIDX_W-1:0] evict_frame,
    input  logic [ADDR_W-1:0] evict_addr,
    output logic              evict_ack,
    output logic              inst_vld,
    output logic [ADDR_W-1:0] inst_addr,
    input  logic              inst_rdy
);

    frame_flags_t      ev_flags;
    logic              q_full;
    logic              push_vld;
    logic [ADDR_W-1:0] push_addr;
    logic              clr_vld;
    logic [FIDX_W-1:0] clr_frame;

    pfl2_frame_tbl #(.FRAMES(FRAMES)) tbl_i (
        .clk        (clk),
        .rst        (rst),
        .fill_vld   (fill_vld),
        .fill_frame (fill_frame),
        .fill_pf    (fill_pf),
        .hit_vld    (hit_vld),
        .hit_frame  (hit_frame),
        .clr_vld    (clr_vld),
        .clr_frame  (clr_frame),
        .rd_frame   (evict_frame),
        .rd_flags   (ev_flags)
    );

    pfl2_evict_dec #(.FRAMES(FRAMES), .ADDR_W(ADDR_W)) dec_i (
        .clk         (clk),
        .rst         (rst),
        .evict_vld   (evict_vld),
        .evict_frame (evict_frame),
        .evict_addr  (evict_addr),
        .evict_flags (ev_flags),
        .hit_vld     (hit_vld),
        .hit_frame   (hit_frame),
        .q_full      (q_full),
        .evict_ack   (evict_ack),
        .push_vld    (push_vld),
        .push_addr   (push_addr),
        .clr_vld     (clr_vld),
        .clr_frame   (clr_frame)
    );

    pfl2_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) q_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push_vld),
        .push_data (push_addr),
        .full      (q_full),
        .out_vld   (inst_vld),
        .out_data  (inst_addr),
        .out_rdy   (inst_rdy)
    );

    // R8: a pending request is held steady while the L2 is not ready
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (inst_vld && !inst_rdy) |=> (inst_vld && $stable(inst_addr)));

    // R2: with nothing pending, only an accepted eviction can raise a request
    a_r2_req_needs_evict: assert property (@(posedge clk) disable iff (rst)
        (!inst_vld && !(evict_vld && evict_ack)) |=> !inst_vld);

endmodule

// File: tb/pfl2_gate_tb.sv
module pfl2_gate_tb_top;

    localparam int FRAMES = 32;
    localparam int ADDR_W = 34;
    localparam int DEPTH  = 4;
    localparam int FIDX_W = $clog2(FRAMES);

    logic              clk = 1'b0;
    logic              rst;
    logic              fill_vld, fill_pf, hit_vld, evict_vld, inst_rdy;
    logic [FIDX_W-1:0] fill_frame, hit_frame, evict_frame;
    logic [ADDR_W-1:0] evict_addr;
    logic              evict_ack, inst_vld;
    logic [ADDR_W-1:0] inst_addr;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [ADDR_W-1:0] exp_q[$];
    bit   pf_m   [FRAMES];
    bit   used_m [FRAMES];

    always #2 clk = ~clk;  // 250 MHz

    pfl2_gate #(.FRAMES(FRAMES), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .fill_vld(fill_vld), .fill_frame(fill_frame), .fill_pf(fill_pf),
        .hit_vld(hit_vld), .hit_frame(hit_frame),
        .evict_vld(evict_vld), .evict_frame(evict_frame), .evict_addr(evict_addr),
        .evict_ack(evict_ack),
        .inst_vld(inst_vld), .inst_addr(inst_addr), .inst_rdy(inst_rdy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares every transfer and every held request to the scoreboard.
    always @(negedge clk) begin
        if (!rst && inst_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected request", longint'(inst_addr), 0);
            end else if (inst_rdy) begin
                check(inst_addr == exp_q[0], "R3 request address/order R8",
                      longint'(inst_addr), longint'(exp_q[0]));
                void'(exp_q.pop_front());
            end else begin
                check(inst_addr == exp_q[0], "R8 held request",
                      longint'(inst_addr), longint'(exp_q[0]));
            end
        end
    end

    task automatic do_fill(input int f, input bit pf);
        @(negedge clk);
        fill_vld = 1'b1; fill_frame = FIDX_W'(f); fill_pf = pf;
        pf_m[f] = pf; used_m[f] = 1'b0;
        @(negedge clk);
        fill_vld = 1'b0;
    endtask

    task automatic do_hit(input int f);
        @(negedge clk);
        hit_vld = 1'b1; hit_frame = FIDX_W'(f);
        if (pf_m[f]) used_m[f] = 1'b1;
        @(negedge clk);
        hit_vld = 1'b0;
    endtask

    // Driver: predicts the outcome, pushes it, then presents the eviction.
    task automatic do_evict(input int f, input logic [ADDR_W-1:0] a, input bit with_hit);
        @(negedge clk);
        if (pf_m[f] && (used_m[f] || with_hit)) exp_q.push_back(a);
        pf_m[f] = 1'b0; used_m[f] = 1'b0;
        evict_vld = 1'b1; evict_frame = FIDX_W'(f); evict_addr = a;
        if (with_hit) begin hit_vld = 1'b1; hit_frame = FIDX_W'(f); end
        while (!evict_ack) @(negedge clk);
        @(negedge clk);
        evict_vld = 1'b0; hit_vld = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(inst_vld == 1'b0, req, inst_vld, 0);
    endtask

    initial begin
        rst = 1'b1;
        fill_vld = 0; fill_pf = 0; hit_vld = 0; evict_vld = 0; inst_rdy = 1'b1;
        fill_frame = '0; hit_frame = '0; evict_frame = '0; evict_addr = '0;
        for (int i = 0; i < FRAMES; i++) begin pf_m[i] = 0; used_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(inst_vld == 1'b0, "R1 reset inst_vld", inst_vld, 0);
        check(evict_ack == 1'b1, "R1 reset evict_ack", evict_ack, 1);

        do_fill(3, 1'b1);
        expect_idle("R2 prefetch fill quiet");

        do_hit(3);
        do_evict(3, 34'h1_0000_0003, 1'b0);
        expect_idle("R3 used prefetch installed");

        do_fill(5, 1'b1);
        do_evict(5, 34'h0_0000_0505, 1'b0);
        expect_idle("R4 unused prefetch dropped");

        do_fill(7, 1'b0);
        do_hit(7); do_hit(7);
        do_evict(7, 34'h0_0777_0000, 1'b0);
        expect_idle("R5 demand fill never installs");

        do_fill(9, 1'b1); do_hit(9); do_fill(9, 1'b1);
        do_evict(9, 34'h2_0000_0009, 1'b0);
        expect_idle("R6 refill clears used");
        do_fill(9, 1'b1); do_hit(9); do_fill(9, 1'b0); do_hit(9);
        do_evict(9, 34'h2_0000_0019, 1'b0);
        expect_idle("R6 demand refill clears prefetched");

        do_fill(11, 1'b1);
        do_evict(11, 34'h3_1111_0000, 1'b1);
        expect_idle("R7 same-cycle hit counts");
        do_evict(11, 34'h3_1111_0001, 1'b0);
        expect_idle("R10 second eviction quiet");

        for (int i = 0; i < 8; i++) do_fill(16 + i, 1'b1);
        for (int i = 0; i < 8; i += 2) do_hit(16 + i);
        for (int i = 0; i < 8; i++) do_evict(16 + i, ADDR_W'(34'h0_00AB_0000 + i), 1'b0);
        expect_idle("R8 ordered mix");

        // R9: fill the FIFO while the L2 is not ready, then stall one more.
        inst_rdy = 1'b0;
        for (int i = 0; i < DEPTH + 1; i++) begin do_fill(i, 1'b1); do_hit(i); end
        for (int i = 0; i < DEPTH; i++) do_evict(i, ADDR_W'(34'h0_0C00_0000 + i), 1'b0);
        @(negedge clk);
        check(evict_ack == 1'b0, "R9 ack low when full", evict_ack, 0);
        exp_q.push_back(ADDR_W'(34'h0_0C00_0000 + DEPTH));
        pf_m[DEPTH] = 1'b0; used_m[DEPTH] = 1'b0;
        evict_vld = 1'b1; evict_frame = FIDX_W'(DEPTH);
        evict_addr = ADDR_W'(34'h0_0C00_0000 + DEPTH);
        repeat (3) @(negedge clk);
        check(evict_ack == 1'b0, "R9 stall holds", evict_ack, 0);
        check(exp_q.size() == DEPTH + 1, "R9 nothing drained", exp_q.size(), DEPTH + 1);
        inst_rdy = 1'b1;
        while (!evict_ack) @(negedge clk);
        @(negedge clk);
        evict_vld = 1'b0;
        expect_idle("R9 drain after stall");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule